// File: doc/BRIEF.md
# Pause Flow Control Resolver

This block settles which directions of Ethernet pause flow control a MAC should honour once a link has come up. When it sees a one-cycle resolve strobe, it looks at the pause abilities that the local station and the link partner advertised during auto-negotiation. It also looks at the mode that software asked for, a strict-standard switch, the media kind (copper or serdes), the auto-negotiation state and the duplex. From these it picks one of four modes: none, receive-only, transmit-only or full.

The chosen mode is turned into the two MAC pause enables. The block also produces the receive-buffer watermark values that steer XOFF and XON generation. Those values are live only while transmit pause is on. Every strobe is answered by a done pulse one cycle later. A requested-mode code outside the legal set is flagged and leaves the active settings as they were.

Top module: `pause_fc_resolver`

## Requirements
- R1: When negotiation runs and both sides advertise symmetric pause, the mode becomes full (code 3) if full was requested, and receive-only (code 1) otherwise.
- R2: When negotiation runs, the local side advertises asymmetric but not symmetric pause, and the partner advertises both, the mode becomes transmit-only (code 2).
- R3: When negotiation runs, the local side advertises both symmetric and asymmetric pause, and the partner advertises asymmetric but not symmetric, the mode becomes receive-only (code 1).
- R4: Any other advertisement pair gives none (code 0) on serdes. On copper it gives none when the request was none or transmit-only or strict mode is set, and receive-only otherwise.
- R5: On copper, a negotiated result under half duplex is forced to none. Serdes results are not affected by duplex.
- R6: Negotiation runs only when auto-negotiation is enabled and complete. A strobe that neither negotiates nor applies the request directly leaves mode, enables and watermarks unchanged.
- R7: With auto-negotiation off on copper, or auto-negotiation failed on serdes, the requested mode is applied directly, with no duplex override.
- R8: Mode codes are none=0, receive-only=1, transmit-only=2 and full=3. Receive enable is on for codes 1 and 3, and transmit enable is on for codes 2 and 3.
- R9: While transmit enable is off, both watermark outputs are zero. While it is on, the high output equals the high level input. The low output equals the low level input, with bit WM_W set exactly when XON sending was configured at the update.
- R10: Outputs update on the clock edge that samples the strobe, and done_o is high for exactly the following cycle. Without a strobe nothing changes.
- R11: A requested-mode code of 4 to 7 sets cfg_err_o and leaves mode, enables and watermarks unchanged. The next strobe carrying a legal code clears cfg_err_o.
- R12: After reset the mode is none, both enables and both watermarks are zero, and done_o and cfg_err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resolve_i | input | 1 | One-cycle request to evaluate the inputs |
| req_mode_i | input | 3 | Requested mode code (0..3 legal) |
| strict_i | input | 1 | Strict-standard fallback selection on copper |
| media_serdes_i | input | 1 | 1 = serdes link, 0 = copper |
| an_enable_i | input | 1 | Auto-negotiation enabled |
| an_complete_i | input | 1 | Auto-negotiation completed |
| an_failed_i | input | 1 | Auto-negotiation failed |
| full_duplex_i | input | 1 | 1 = full duplex link |
| loc_sym_i | input | 1 | Local symmetric pause advertised |
| loc_asym_i | input | 1 | Local asymmetric pause advertised |
| lp_sym_i | input | 1 | Partner symmetric pause advertised |
| lp_asym_i | input | 1 | Partner asymmetric pause advertised |
| send_xon_i | input | 1 | Emit XON when the buffer drains below the low level |
| low_level_i | input | WM_W | Configured low (XON) level |
| high_level_i | input | WM_W | Configured high (XOFF) level |
| mode_o | output | 2 | Resolved mode code |
| tx_pause_en_o | output | 1 | MAC transmit pause enable |
| rx_pause_en_o | output | 1 | MAC receive pause enable |
| low_mark_o | output | WM_W+1 | Low watermark, XON flag in the top bit |
| high_mark_o | output | WM_W | High watermark |
| done_o | output | 1 | Pulse one cycle after each strobe |
| cfg_err_o | output | 1 | Last strobe carried an illegal request code |

## Verification
A corrupted mode register would make the pause enables disagree with the mode code as soon as it occurs, or would give a different code one cycle after the next strobe. A bad watermark register shows up as nonzero marks while transmit pause is off. A wrong hold decision, such as updating on an incomplete negotiation or an illegal code, changes the outputs in the cycle right after that strobe. The bench's per-cycle reference comparison catches it there, before the next stimulus.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_RX   = 2'd1,
    FC_TX   = 2'd2,
    FC_FULL = 2'd3
  } fc_mode_e;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_FORCE = 2'd1,
    ACT_NEG   = 2'd2,
    ACT_ERR   = 2'd3
  } fc_act_e;

  localparam int REQ_W = 3;

  function automatic logic req_legal(input logic [REQ_W-1:0] code);
    return (code[REQ_W-1:2] == '0);
  endfunction

endpackage

// File: rtl/pfc_negotiate.sv
module pfc_negotiate
  import pfc_pkg::*;
(
  input  logic     loc_sym,
  input  logic     loc_asym,
  input  logic     lp_sym,
  input  logic     lp_asym,
  input  fc_mode_e req,
  input  logic     strict,
  input  logic     serdes,
  input  logic     full_duplex,
  output fc_mode_e result
);

  fc_mode_e raw;
  logic     want_none;

  // Copper fallback goes to none for requests that never receive pause.
  assign want_none = strict || (req == FC_NONE) || (req == FC_TX);

  always_comb begin
    if (loc_sym && lp_sym) begin
      raw = (req == FC_FULL) ? FC_FULL : FC_RX;
    end else if (!loc_sym && loc_asym && lp_sym && lp_asym) begin
      raw = FC_TX;
    end else if (loc_sym && loc_asym && !lp_sym && lp_asym) begin
      raw = FC_RX;
    end else if (serdes) begin
      raw = FC_NONE;
    end else begin
      raw = want_none ? FC_NONE : FC_RX;
    end
  end

  // Half duplex cannot carry pause on copper.
  assign result = (!serdes && !full_duplex) ? FC_NONE : raw;

endmodule

// File: rtl/pfc_enable_map.sv
module pfc_enable_map
  import pfc_pkg::*;
(
  input  fc_mode_e mode,
  output logic     tx_en,
  output logic     rx_en
);

  always_comb begin
    unique case (mode)
      FC_NONE: begin tx_en = 1'b0; rx_en = 1'b0; end
      FC_RX:   begin tx_en = 1'b0; rx_en = 1'b1; end
      FC_TX:   begin tx_en = 1'b1; rx_en = 1'b0; end
      default: begin tx_en = 1'b1; rx_en = 1'b1; end
    endcase
  end

endmodule

// File: rtl/pfc_watermark.sv
module pfc_watermark #(
  parameter int WM_W = 16
) (
  input  logic            tx_en,
  input  logic            send_xon,
  input  logic [WM_W-1:0] low_level,
  input  logic [WM_W-1:0] high_level,
  output logic [WM_W:0]   low_mark,
  output logic [WM_W-1:0] high_mark
);

  always_comb begin
    if (tx_en) begin
      low_mark  = {send_xon, low_level};
      high_mark = high_level;
    end else begin
      low_mark  = '0;
      high_mark = '0;
    end
  end

endmodule

// File: rtl/pause_fc_resolver.sv
module pause_fc_resolver
  import pfc_pkg::*;
#(
  parameter int WM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resolve_i,
  input  logic [REQ_W-1:0] req_mode_i,
  input  logic             strict_i,
  input  logic             media_serdes_i,
  input  logic             an_enable_i,
  input  logic             an_complete_i,
  input  logic             an_failed_i,
  input  logic             full_duplex_i,
  input  logic             loc_sym_i,
  input  logic             loc_asym_i,
  input  logic             lp_sym_i,
  input  logic             lp_asym_i,
  input  logic             send_xon_i,
  input  logic [WM_W-1:0]  low_level_i,
  input  logic [WM_W-1:0]  high_level_i,
  output logic [1:0]       mode_o,
  output logic             tx_pause_en_o,
  output logic             rx_pause_en_o,
  output logic [WM_W:0]    low_mark_o,
  output logic [WM_W-1:0]  high_mark_o,
  output logic             done_o,
  output logic             cfg_err_o
);

  localparam int SYNC_STAGES = 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[SYNC_STAGES-1];

  fc_mode_e        req_mode, neg_mode, mode_q, mode_nxt;
  fc_act_e         act;
  logic            req_ok, direct;
  logic            upd_en;
  logic            tx_q, rx_q, tx_nxt, rx_nxt;
  logic [WM_W:0]   low_q, low_nxt;
  logic [WM_W-1:0] high_q, high_nxt;
  logic            done_q, err_q, err_nxt;

  assign req_ok   = req_legal(req_mode_i);
  assign req_mode = fc_mode_e'(req_mode_i[1:0]);
  assign direct   = (media_serdes_i && an_failed_i) ||
                    (!media_serdes_i && !an_enable_i);

  pfc_negotiate u_neg (
    .loc_sym     (loc_sym_i),
    .loc_asym    (loc_asym_i),
    .lp_sym      (lp_sym_i),
    .lp_asym     (lp_asym_i),
    .req         (req_mode),
    .strict      (strict_i),
    .serdes      (media_serdes_i),
    .full_duplex (full_duplex_i),
    .result      (neg_mode)
  );

  // Action select: illegal code wins, then direct application, then negotiation.
  always_comb begin
    act = ACT_HOLD;
    if (resolve_i) begin
      if (!req_ok)                           act = ACT_ERR;
      else if (direct)                       act = ACT_FORCE;
      else if (an_enable_i && an_complete_i) act = ACT_NEG;
      else                                   act = ACT_HOLD;
    end
  end

  always_comb begin
    mode_nxt = mode_q;
    upd_en   = 1'b0;
    unique case (act)
      ACT_FORCE: begin mode_nxt = req_mode; upd_en = 1'b1; end
      ACT_NEG:   begin mode_nxt = neg_mode; upd_en = 1'b1; end
      default:   begin mode_nxt = mode_q;   upd_en = 1'b0; end
    endcase
    err_nxt = resolve_i ? !req_ok : err_q;
  end

  pfc_enable_map u_map (
    .mode  (mode_nxt),
    .tx_en (tx_nxt),
    .rx_en (rx_nxt)
  );

  pfc_watermark #(.WM_W(WM_W)) u_wm (
    .tx_en      (tx_nxt),
    .send_xon   (send_xon_i),
    .low_level  (low_level_i),
    .high_level (high_level_i),
    .low_mark   (low_nxt),
    .high_mark  (high_nxt)
  );

  // Settings registers, clock-enabled by upd_en.
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mode_q <= FC_NONE;
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
      low_q  <= '0;
      high_q <= '0;
    end else if (upd_en) begin
      mode_q <= mode_nxt;
      tx_q   <= tx_nxt;
      rx_q   <= rx_nxt;
      low_q  <= low_nxt;
      high_q <= high_nxt;
    end
  end

  // Status registers.
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= resolve_i;
      err_q  <= err_nxt;
    end
  end

  assign mode_o        = mode_q;
  assign tx_pause_en_o = tx_q;
  assign rx_pause_en_o = rx_q;
  assign low_mark_o    = low_q;
  assign high_mark_o   = high_q;
  assign done_o        = done_q;
  assign cfg_err_o     = err_q;

endmodule

// File: rtl/pfc_resolver_chk.sv
module pfc_resolver_chk #(
  parameter int WM_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            resolve_i,
  input logic [2:0]      req_mode_i,
  input logic            media_serdes_i,
  input logic            an_enable_i,
  input logic            an_complete_i,
  input logic            an_failed_i,
  input logic            full_duplex_i,
  input logic            loc_sym_i,
  input logic            lp_sym_i,
  input logic [1:0]      mode_o,
  input logic            tx_pause_en_o,
  input logic            rx_pause_en_o,
  input logic [WM_W:0]   low_mark_o,
  input logic [WM_W-1:0] high_mark_o,
  input logic            done_o,
  input logic            cfg_err_o
);

  logic legal_c, direct_c, neg_c;
  assign legal_c  = (req_mode_i[2] == 1'b0);
  assign direct_c = (media_serdes_i && an_failed_i) || (!media_serdes_i && !an_enable_i);
  assign neg_c    = resolve_i && legal_c && !direct_c && an_enable_i && an_complete_i;

  // R1
  a_r1_both_sym: assert property (@(posedge clk) disable iff (!rst_n)
    neg_c && loc_sym_i && lp_sym_i && (media_serdes_i || full_duplex_i)
    |=> mode_o == (($past(req_mode_i) == 3'd3) ? 2'd3 : 2'd1));

  // R5
  a_r5_half_duplex: assert property (@(posedge clk) disable iff (!rst_n)
    neg_c && !media_serdes_i && !full_duplex_i |=> mode_o == 2'd0);

  // R6
  a_r6_incomplete_hold: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_i && legal_c && !direct_c && !(an_enable_i && an_complete_i)
    |=> $stable(mode_o) && $stable(low_mark_o) && $stable(high_mark_o));

  // R7
  a_r7_direct: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_i && legal_c && direct_c |=> mode_o == $past(req_mode_i[1:0]));

  // R8
  a_r8_enable_map: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pause_en_o == mode_o[1]) && (rx_pause_en_o == (mode_o == 2'd1 || mode_o == 2'd3)));

  // R9
  a_r9_marks_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_pause_en_o |-> (low_mark_o == '0) && (high_mark_o == '0));

  // R10
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_i |=> done_o);

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !resolve_i |=> !done_o && $stable(mode_o) && $stable(cfg_err_o) && $stable(low_mark_o));

  // R11
  a_r11_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_i && !legal_c |=> cfg_err_o && $stable(mode_o) && $stable(high_mark_o));

endmodule

bind pause_fc_resolver pfc_resolver_chk #(.WM_W(WM_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_q_n),
  .resolve_i      (resolve_i),
  .req_mode_i     (req_mode_i),
  .media_serdes_i (media_serdes_i),
  .an_enable_i    (an_enable_i),
  .an_complete_i  (an_complete_i),
  .an_failed_i    (an_failed_i),
  .full_duplex_i  (full_duplex_i),
  .loc_sym_i      (loc_sym_i),
  .lp_sym_i       (lp_sym_i),
  .mode_o         (mode_o),
  .tx_pause_en_o  (tx_pause_en_o),
  .rx_pause_en_o  (rx_pause_en_o),
  .low_mark_o     (low_mark_o),
  .high_mark_o    (high_mark_o),
  .done_o         (done_o),
  .cfg_err_o      (cfg_err_o)
);

// File: tb/pause_fc_resolver_bench.sv
module pause_fc_resolver_bench;

  localparam int WM_W = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            resolve_i = 1'b0;
  logic [2:0]      req_mode_i = 3'd0;
  logic            strict_i = 1'b0;
  logic            media_serdes_i = 1'b0;
  logic            an_enable_i = 1'b1;
  logic            an_complete_i = 1'b1;
  logic            an_failed_i = 1'b0;
  logic            full_duplex_i = 1'b1;
  logic            loc_sym_i = 1'b0;
  logic            loc_asym_i = 1'b0;
  logic            lp_sym_i = 1'b0;
  logic            lp_asym_i = 1'b0;
  logic            send_xon_i = 1'b0;
  logic [WM_W-1:0] low_level_i = 16'h0123;
  logic [WM_W-1:0] high_level_i = 16'h0456;
  logic [1:0]      mode_o;
  logic            tx_pause_en_o, rx_pause_en_o, done_o, cfg_err_o;
  logic [WM_W:0]   low_mark_o;
  logic [WM_W-1:0] high_mark_o;

  int checks = 0;
  int failures = 0;
  string cur_tag = "R12";
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pause_fc_resolver #(.WM_W(WM_W)) u_pause_fc_resolver (.*);

  // Behavioural reference model
  int m_mode, m_tx, m_rx, m_low, m_high, m_done, m_err;

  function automatic int ref_negotiate();
    int r;
    int req = int'(req_mode_i);
    if (loc_sym_i && lp_sym_i)                              r = (req == 3) ? 3 : 1;
    else if (lp_sym_i && lp_asym_i && loc_asym_i && !loc_sym_i) r = 2;
    else if (lp_asym_i && !lp_sym_i && loc_sym_i && loc_asym_i) r = 1;
    else if (media_serdes_i)                                r = 0;
    else if (strict_i || req == 0 || req == 2)              r = 0;
    else                                                    r = 1;
    if (!media_serdes_i && !full_duplex_i) r = 0;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_tx = 0; m_rx = 0; m_low = 0; m_high = 0; m_done = 0; m_err = 0;
    end else begin
      int nm;
      m_done = resolve_i ? 1 : 0;
      if (resolve_i) begin
        if (req_mode_i > 3) m_err = 1;
        else begin
          m_err = 0;
          nm = -1;
          if ((media_serdes_i && an_failed_i) || (!media_serdes_i && !an_enable_i))
            nm = int'(req_mode_i);
          else if (an_enable_i && an_complete_i)
            nm = ref_negotiate();
          if (nm >= 0) begin
            m_mode = nm;
            m_tx   = (nm >= 2) ? 1 : 0;
            m_rx   = (nm % 2 == 1) ? 1 : 0;
            m_low  = m_tx ? (int'(send_xon_i) * 65536 + int'(low_level_i)) : 0;
            m_high = m_tx ? int'(high_level_i) : 0;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk({cur_tag, " model mode"}, int'(mode_o), m_mode);
      chk({cur_tag, " model R8 tx"}, int'(tx_pause_en_o), m_tx);
      chk({cur_tag, " model R8 rx"}, int'(rx_pause_en_o), m_rx);
      chk({cur_tag, " model R9 low"}, int'(low_mark_o), m_low);
      chk({cur_tag, " model R9 high"}, int'(high_mark_o), m_high);
      chk({cur_tag, " model R10 done"}, int'(done_o), m_done);
      chk({cur_tag, " model R11 err"}, int'(cfg_err_o), m_err);
    end
  end

  task automatic link(input bit serdes, input bit an_en, input bit an_cmp,
                      input bit an_fail, input bit fd);
    media_serdes_i = serdes; an_enable_i = an_en; an_complete_i = an_cmp;
    an_failed_i = an_fail; full_duplex_i = fd;
  endtask

  task automatic adv(input bit ls, input bit la, input bit ps, input bit pa);
    loc_sym_i = ls; loc_asym_i = la; lp_sym_i = ps; lp_asym_i = pa;
  endtask

  // Strobe once; return at the negedge where the result is visible.
  task automatic strobe(input string tag, input int req);
    cur_tag = tag;
    @(negedge clk);
    req_mode_i = 3'(req);
    resolve_i = 1'b1;
    @(negedge clk);
    resolve_i = 1'b0;
    chk({tag, " R10 done"}, int'(done_o), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 mode", int'(mode_o), 0);
    chk("R12 tx", int'(tx_pause_en_o), 0);
    chk("R12 low", int'(low_mark_o), 0);
    chk("R12 err", int'(cfg_err_o), 0);

    // R1 full on copper, full duplex
    link(0, 1, 1, 0, 1); adv(1, 0, 1, 0); send_xon_i = 1;
    strobe("R1", 3);
    chk("R1 mode", int'(mode_o), 3);
    chk("R8 full enables", int'({tx_pause_en_o, rx_pause_en_o}), 3);
    chk("R9 low with xon", int'(low_mark_o), 'h10123);
    chk("R9 high", int'(high_mark_o), 'h0456);
    strobe("R1", 2);
    chk("R1 rx fallback", int'(mode_o), 1);
    chk("R9 marks off", int'(low_mark_o) + int'(high_mark_o), 0);

    // R2
    send_xon_i = 0; adv(0, 1, 1, 1);
    strobe("R2", 1);
    chk("R2 mode", int'(mode_o), 2);
    chk("R9 low no xon", int'(low_mark_o), 'h0123);
    // R3
    adv(1, 1, 0, 1);
    strobe("R3", 0);
    chk("R3 mode", int'(mode_o), 1);

    // R4 fallbacks
    adv(0, 0, 1, 1);
    strobe("R4", 3);
    chk("R4 copper rx", int'(mode_o), 1);
    strict_i = 1;
    strobe("R4", 3);
    chk("R4 copper strict", int'(mode_o), 0);
    strict_i = 0;
    strobe("R4", 3);
    strobe("R4", 2);
    chk("R4 copper tx req", int'(mode_o), 0);
    link(1, 1, 1, 0, 1);
    strobe("R4", 3);
    chk("R4 serdes none", int'(mode_o), 0);

    // R5 duplex
    adv(1, 1, 1, 1); link(1, 1, 1, 0, 0);
    strobe("R5", 3);
    chk("R5 serdes half keeps", int'(mode_o), 3);
    link(0, 1, 1, 0, 0);
    strobe("R5", 3);
    chk("R5 copper half none", int'(mode_o), 0);

    // R6 incomplete negotiation holds
    link(0, 1, 1, 0, 1);
    strobe("R6", 3);
    link(0, 1, 0, 0, 1);
    strobe("R6", 1);
    chk("R6 hold", int'(mode_o), 3);
    link(1, 0, 0, 0, 1);
    strobe("R6", 0);
    chk("R6 serdes an off hold", int'(mode_o), 3);

    // R7 direct application
    link(0, 0, 0, 0, 0);
    strobe("R7", 2);
    chk("R7 copper an off", int'(mode_o), 2);
    link(1, 1, 0, 1, 1);
    strobe("R7", 1);
    chk("R7 serdes failed", int'(mode_o), 1);

    // R11 illegal request
    strobe("R11", 6);
    chk("R11 err", int'(cfg_err_o), 1);
    chk("R11 mode kept", int'(mode_o), 1);
    strobe("R11", 3);
    chk("R11 err cleared", int'(cfg_err_o), 0);

    // R10 no strobe -> no change
    cur_tag = "R10";
    link(0, 0, 0, 0, 1); req_mode_i = 3'd0;
    repeat (3) @(negedge clk);
    chk("R10 stable", int'(mode_o), 3);
    chk("R10 no done", int'(done_o), 0);

    // Mixed sweep compared against the model each cycle
    for (int i = 0; i < 256; i++) begin
      link(i[0], i[1], i[2], i[3] & i[6], i[4]);
      adv(i[5], i[6], i[7], i[2] ^ i[5]);
      strict_i = i[3];
      send_xon_i = i[1] ^ i[7];
      strobe("R4", (i * 5) % 8);
    end

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule